// File: doc/BRIEF.md
# Digital Band-Gap Code Pipeline

This block turns a stream of converter results from two junction-voltage channels into one digital reference code for a DAC. Each result comes with a one-bit channel tag. Tag 0 marks the low-current junction and tag 1 marks the high-current junction. The block averages each channel on its own over a fixed number of samples. It subtracts the low-current average from the high-current average and scales that difference by a fixed-point constant. It then adds the high-current average back, which gives a sum one bit wider than a converter result.

That sum is halved with round-half-to-even, so the output code has the converter's width. The rounding adds no systematic bias. A code is produced only once both channels have delivered a fresh average. It is clamped to the valid code range and never wraps. The scale constant is an unsigned input with eight fractional bits, for example 1505 for about 5.88.

Top module: `bandgap_code_pipe`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` and `out_code` are 0.
- R2: Each channel collects AVG_LEN valid samples that carry its tag, in non-overlapping groups. Each group yields the average floor(sum/AVG_LEN). Cycles with `in_valid` low have no effect, whatever `in_chan` and `in_sample` hold.
- R3: The difference term is the channel-1 average minus the channel-0 average, and it may be negative.
- R4: The difference is multiplied by `scale_m`, read as an unsigned value with 8 fractional bits. The product is floored toward minus infinity to an integer. The channel-1 average is then added to give the sum S.
- R5: The output code is S/2. An exact half rounds to the even neighbour, so S=5 gives 2 and S=7 gives 4.
- R6: When S is negative the code is 0. When S/2 after rounding exceeds 2^SMP_W-1, the code is 2^SMP_W-1.
- R7: One code is issued per pair of fresh averages, one from each channel. If a channel finishes a second average before the other channel finishes its first, the newer average replaces the older one. `out_valid` is a single-cycle pulse.
- R8: `out_valid` rises on the third clock edge after the edge that accepts the sample completing the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 1 | Channel tag: 0 low-current, 1 high-current |
| in_sample | input | SMP_W | Unsigned converter result |
| scale_m | input | M_W | Unsigned scale constant, M_FRAC fractional bits |
| out_valid | output | 1 | Code strobe |
| out_code | output | SMP_W | Reference code for the DAC |

## Verification
Some properties are checked by assertions on every cycle. Averages appear only on the cycle after an accepted sample and never on two cycles in a row. An odd sum below the ceiling always yields an even code. A negative sum yields 0 and an oversized sum yields the ceiling. Output strobes are never back to back.

Other behaviours only the bench's scenarios can show. These are the floor of the average, the sign handling of the difference, the floor of the scaled product, the replacement of a stale average, the exact latency, and whether invalid cycles are ignored. The bench shows them by comparing every cycle against a behavioural model.

// File: rtl/bgr_pkg.sv
`timescale 1ns/1ps
package bgr_pkg;
   typedef enum logic {
      CH_LOW  = 1'b0,
      CH_HIGH = 1'b1
   } chan_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bgr_boxcar.sv
`timescale 1ns/1ps
module bgr_boxcar #(
   parameter int DW  = 11,
   parameter int LEN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_v,
   input  logic [DW-1:0] smp,
   output logic          avg_v,
   output logic [DW-1:0] avg
);
   import bgr_pkg::*;

   localparam int CW  = $clog2(LEN);
   localparam int SW  = DW + $clog2(LEN);
   localparam int RS  = SW + $clog2(LEN) + 1;

   initial begin : elab_chk
      if (LEN < 2)  $fatal(1, "LEN must be at least 2");
      if (RS > 30)  $fatal(1, "reciprocal shift too wide");
   end

   logic [CW-1:0] cnt;
   logic [SW-1:0] acc;
   logic [SW-1:0] total;
   logic [DW-1:0] quot;
   logic          last;

   assign total = acc + SW'(smp);
   assign last  = smp_v && (cnt == CW'(LEN - 1));

   generate
      if (is_pow2(LEN)) begin : g_shift
         assign quot = DW'(total >> $clog2(LEN));
      end else begin : g_recip
         localparam int PRW = SW + RS + 1;
         localparam int RECIP = ((1 << RS) + LEN - 1) / LEN;
         logic [PRW-1:0] prod;
         assign prod = PRW'(total) * PRW'(RECIP);
         assign quot = DW'(prod >> RS);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         acc   <= '0;
         avg_v <= 1'b0;
         avg   <= '0;
      end else begin
         avg_v <= 1'b0;
         if (last) begin
            cnt   <= '0;
            acc   <= '0;
            avg_v <= 1'b1;
            avg   <= quot;
         end else if (smp_v) begin
            cnt <= cnt + 1'b1;
            acc <= total;
         end
      end
   end

   AST_AVG_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      avg_v |-> $past(smp_v)); // R2
   AST_AVG_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      avg_v |=> !avg_v); // R2
endmodule

// File: rtl/bgr_combine.sv
`timescale 1ns/1ps
module bgr_combine #(
   parameter int DW   = 11,
   parameter int MW   = 12,
   parameter int FRAC = 8,
   parameter int PW   = DW + MW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lo_v,
   input  logic [DW-1:0]        lo,
   input  logic                 hi_v,
   input  logic [DW-1:0]        hi,
   input  logic [MW-1:0]        scale,
   output logic                 sum_v,
   output logic signed [PW-1:0] sum
);
   logic [DW-1:0]        lo_r, hi_r;
   logic                 lo_f, hi_f, fire;
   logic signed [DW:0]   diff;
   logic signed [PW-1:0] prod, scaled, total;

   assign fire   = lo_f && hi_f;
   assign diff   = $signed({1'b0, hi_r}) - $signed({1'b0, lo_r});
   assign prod   = PW'(diff) * PW'($signed({1'b0, scale}));
   assign scaled = prod >>> FRAC;
   assign total  = scaled + PW'($signed({1'b0, hi_r}));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_r  <= '0;
         hi_r  <= '0;
         lo_f  <= 1'b0;
         hi_f  <= 1'b0;
         sum_v <= 1'b0;
         sum   <= '0;
      end else begin
         lo_f  <= lo_v || (lo_f && !fire);
         hi_f  <= hi_v || (hi_f && !fire);
         if (lo_v) lo_r <= lo;
         if (hi_v) hi_r <= hi;
         sum_v <= fire;
         if (fire) sum <= total;
      end
   end
endmodule

// File: rtl/bgr_round.sv
`timescale 1ns/1ps
module bgr_round #(
   parameter int DW = 11,
   parameter int PW = 25
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sum_v,
   input  logic signed [PW-1:0] sum,
   output logic                 code_v,
   output logic [DW-1:0]        code
);
   localparam logic [DW-1:0] MAXC = {DW{1'b1}};

   logic [PW-1:0] half, rnd;
   logic          up;
   logic [DW-1:0] code_n;

   assign half = {1'b0, sum[PW-1:1]};
   assign up   = sum[0] && half[0];
   assign rnd  = half + PW'(up);

   always_comb begin
      if (sum[PW-1])                code_n = '0;
      else if (rnd > PW'(MAXC))     code_n = MAXC;
      else                          code_n = rnd[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_v <= 1'b0;
         code   <= '0;
      end else begin
         code_v <= sum_v;
         if (sum_v) code <= code_n;
      end
   end

   AST_HALF_TO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_v && sum[0] && !sum[PW-1]) |=> (code_v && (!code[0] || code == MAXC))); // R5
   AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_v && !sum[PW-1] && (sum >= $signed(PW'(2 * int'(MAXC) + 1)))) |=> (code == MAXC)); // R6
   AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_v && sum[PW-1]) |=> (code == '0)); // R6
endmodule

// File: rtl/bandgap_code_pipe.sv
`timescale 1ns/1ps
module bandgap_code_pipe #(
   parameter int SMP_W   = 11,
   parameter int AVG_LEN = 8,
   parameter int M_W     = 12,
   parameter int M_FRAC  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_chan,
   input  logic [SMP_W-1:0] in_sample,
   input  logic [M_W-1:0]   scale_m,
   output logic             out_valid,
   output logic [SMP_W-1:0] out_code
);
   import bgr_pkg::*;

   localparam int PW = SMP_W + M_W + 2;

   initial begin : elab_chk
      if (SMP_W < 2)       $fatal(1, "SMP_W too small");
      if (M_FRAC >= M_W)   $fatal(1, "M_FRAC must be below M_W");
      if (AVG_LEN < 2)     $fatal(1, "AVG_LEN must be at least 2");
   end

   logic [1:0]       ch_v;
   logic [SMP_W-1:0] ch_avg [2];
   logic             sum_v;
   logic signed [PW-1:0] sum;

   generate
      for (genvar c = 0; c < 2; c++) begin : g_ch
         localparam chan_e TAG = (c == 0) ? CH_LOW : CH_HIGH;
         bgr_boxcar #(.DW(SMP_W), .LEN(AVG_LEN)) u_box (
            .clk   (clk),
            .rst_n (rst_n),
            .smp_v (in_valid && (in_chan == TAG)),
            .smp   (in_sample),
            .avg_v (ch_v[c]),
            .avg   (ch_avg[c])
         );
      end
   endgenerate

   bgr_combine #(.DW(SMP_W), .MW(M_W), .FRAC(M_FRAC), .PW(PW)) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_v  (ch_v[0]),
      .lo    (ch_avg[0]),
      .hi_v  (ch_v[1]),
      .hi    (ch_avg[1]),
      .scale (scale_m),
      .sum_v (sum_v),
      .sum   (sum)
   );

   bgr_round #(.DW(SMP_W), .PW(PW)) u_rnd (
      .clk    (clk),
      .rst_n  (rst_n),
      .sum_v  (sum_v),
      .sum    (sum),
      .code_v (out_valid),
      .code   (out_code)
   );

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R7
endmodule

// File: tb/bandgap_code_pipe_test.sv
`timescale 1ns/1ps
module bandgap_code_pipe_test;
   localparam int DW   = 11;
   localparam int L    = 8;
   localparam int MW   = 12;
   localparam int MAXC = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_chan = 1'b0;
   logic [DW-1:0] in_sample = '0;
   logic [MW-1:0] scale_m = '0;
   logic          out_valid;
   logic [DW-1:0] out_code;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   // behavioural model state
   int    macc [2];
   int    mcnt [2];
   int    mavg [2];
   bit    mfresh [2];
   int    due_q [$];
   int    code_q [$];
   string tag_q [$];
   string cur_tag = "R2";

   bandgap_code_pipe #(.SMP_W(DW), .AVG_LEN(L), .M_W(MW), .M_FRAC(8)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_sample(in_sample), .scale_m(scale_m),
      .out_valid(out_valid), .out_code(out_code));

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int conv(input int s);
      int q;
      if (s < 0) return 0;
      q = s / 2;
      if ((s % 2 == 1) && (q % 2 == 1)) q = q + 1;
      if (q > MAXC) q = MAXC;
      return q;
   endfunction

   function automatic int ref_code(input int hi, input int lo, input int m);
      int p;
      p = ((hi - lo) * m) >>> 8;
      return conv(hi + p);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic model_sample(input int ch, input int v, input int edge_no);
      macc[ch] += v;
      mcnt[ch] += 1;
      if (mcnt[ch] == L) begin
         mavg[ch]   = macc[ch] / L;
         macc[ch]   = 0;
         mcnt[ch]   = 0;
         mfresh[ch] = 1;
         if (mfresh[0] && mfresh[1]) begin
            due_q.push_back(edge_no + 3);                        // R8
            code_q.push_back(ref_code(mavg[1], mavg[0], int'(scale_m)));
            tag_q.push_back(cur_tag);
            mfresh[0] = 0;
            mfresh[1] = 0;
         end
      end
   endtask

   task automatic send(input int ch, input int v);
      @(negedge clk);
      in_valid  = 1'b1;
      in_chan   = ch[0];
      in_sample = DW'(v);
      model_sample(ch, v, cyc + 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_chan   = 1'($urandom);           // junk on invalid cycles, R2
         in_sample = DW'($urandom);
      end
   endtask

   task automatic pair_const(input int lo, input int hi, input int m, input string tag);
      idle(2);
      scale_m = MW'(m);
      cur_tag = tag;
      for (int i = 0; i < L; i++) begin
         send(0, lo);
         send(1, hi);
      end
      idle(6);
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_v;
         exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
         if (out_valid || exp_v) begin
            check(out_valid == exp_v, exp_v ? {tag_q[0], " strobe R8"} : "R7 unexpected strobe",
                  int'(out_valid), int'(exp_v));
            if (exp_v) begin
               check(out_code == DW'(code_q[0]), tag_q[0], int'(out_code), code_q[0]);
               void'(due_q.pop_front());
               void'(code_q.pop_front());
               void'(tag_q.pop_front());
            end
         end else if (due_q.size() > 0 && due_q[0] < cyc) begin
            check(1'b0, "R8 missed strobe", 0, 1);
            void'(due_q.pop_front());
            void'(code_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      for (int c = 0; c < 2; c++) begin
         macc[c] = 0; mcnt[c] = 0; mavg[c] = 0; mfresh[c] = 0;
      end
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      check(out_code == '0, "R1 code in reset", int'(out_code), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(out_code == '0, "R1 code after reset", int'(out_code), 0);

      // R2: floor of a non-integer average (lo 3.5 -> 3, hi 13.5 -> 13, S=13 -> 6)
      idle(2);
      scale_m = '0;
      cur_tag = "R2 floor average";
      for (int i = 0; i < L; i++) begin
         send(0, i);
         idle(1);
         send(1, 10 + i);
      end
      idle(6);

      // R5: halves round to even with the difference switched off
      pair_const(0, 3, 0, "R5 S=3");
      pair_const(0, 5, 0, "R5 S=5");
      pair_const(0, 7, 0, "R5 S=7");
      pair_const(0, 4, 0, "R5 S=4");

      // R4 / R3: positive and negative difference with M about 5.88
      pair_const(900, 1000, 1505, "R4 positive diff");
      pair_const(1000, 900, 1505, "R3 negative diff");
      pair_const(500, 700, 256, "R4 unity scale");

      // R6: clamping at both ends
      pair_const(0, 2047, 1505, "R6 ceiling");
      pair_const(2047, 0, 256, "R6 floor zero");
      pair_const(0, 2046, 0, "R6 just below ceiling");

      // R7: stale low average replaced by the newer one
      idle(2);
      scale_m = MW'(1505);
      cur_tag = "R7 replacement";
      for (int i = 0; i < L; i++) send(0, 100);
      idle(3);
      for (int i = 0; i < L; i++) send(0, 300);
      idle(3);
      for (int i = 0; i < L; i++) send(1, 400);
      idle(6);

      // R4: random samples, tags, gaps and scale
      for (int r = 0; r < 40; r++) begin
         idle(6);
         scale_m = MW'($urandom_range(0, 2047));
         cur_tag = "R4 random";
         for (int i = 0; i < 3 * L; i++) begin
            send(int'($urandom_range(0, 1)), int'($urandom_range(0, MAXC)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
         end
      end
      idle(10);
      check(due_q.size() == 0, "R7 all expected codes issued", due_q.size(), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule